// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Idle Frames

This block is the sending half of an asynchronous serial port. It turns a byte (or a 9-bit word) into a frame on one serial line. The frame is a low start bit, the data bits sent least significant first, and a high stop bit. Software can also ask for two special frames. A break frame holds the line low for one whole frame time. An idle frame holds the line high for one whole frame time.

The host side works like a small register set. Writing a data word loads a one-word holding buffer, and `data_empty` shows when that buffer can take another word. A word-length bit picks 8 data bits (10-bit frames) or 9 data bits (11-bit frames). A line-enable bit lets frames go out. Turning the enable off and back on queues one idle frame. A rising edge on the break bit queues one break. If the break bit is still set when a break frame ends, another break follows straight after.

The bit rate comes from `tick`, a clock enable from the system clock, divided by a programmable count. Every frame restarts that divider when it loads, so frame and bit lengths do not depend on when a request arrives. `tx_done` shows that the line has gone quiet and nothing is waiting.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, with the line enable low, `txd` is 1, `data_empty` is 1 and `tx_done` is 1.
- R2: With `long_word`=0, a data frame is one low start bit, then `wr_data[7:0]` least significant bit first, then one high stop bit. Each bit lasts `baud_div`+1 cycles in which `tick` is high.
- R3: With `long_word`=1, a data frame carries 9 data bits, `wr_data[0]` first and `wr_data[8]` last, before the stop bit.
- R4: A pulse on `brk_req` that ends before the break frame does gives exactly one low period. It lasts exactly 10 bit times (`long_word`=0) or 11 bit times (`long_word`=1), whatever its timing against the bit clock.
- R5: While `brk_req` stays high, breaks go out back to back. Each one has the exact length from R4, and there is exactly one high bit time between them.
- R6: After every break the line stays high for at least one bit time before the next start bit.
- R7: A rising edge of `tx_en` queues one idle frame, with the line high for 10 or 11 bit times. With `tick` held high, `tx_done` first reads 1 exactly 2 + nbits×(`baud_div`+1) cycles after the edge where `tx_en` was raised.
- R8: An idle request followed at once by a break request gives the idle frame first, then a single break of exact length. The first low cycle comes 2 + nbits×(`baud_div`+1) cycles after the edge where `tx_en` was raised.
- R9: When `tx_en` falls during a frame, that frame finishes unchanged, and then `txd` stays 1. A word still waiting keeps `data_empty` at 0 and goes out after the idle frame once `tx_en` is raised again.
- R10: A write makes `data_empty` 0 and `tx_done` 0 from the next cycle. `tx_done` stays 0 while a frame is running or any data, idle or break request is waiting.
- R11: When several requests wait at a frame boundary, idle goes first, then break, then data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable that drives the bit-rate divider |
| baud_div | input | DIV_W | Bit time minus one, counted in `tick` cycles |
| wr_data | input | 9 | Word to send; bit 8 is used only when `long_word`=1 |
| wr_stb | input | 1 | One-cycle write strobe that loads the holding buffer |
| long_word | input | 1 | 0: 8 data bits, 10-bit frames; 1: 9 data bits, 11-bit frames |
| tx_en | input | 1 | Line enable; a rising edge queues an idle frame |
| brk_req | input | 1 | Break request; a rising edge queues one break, holding it high repeats breaks |
| txd | output | 1 | Serial output line; high when no frame is running |
| data_empty | output | 1 | Holding buffer can take a new word |
| tx_done | output | 1 | No frame running and no request waiting |

## Verification
With `tick` held high, a frame starts on the second clock edge after a request edge. The first clock edge registers the request and the second loads the shifter, so the first low cycle of a break or start bit, and the end of an idle frame, come at a fixed count: 2 + nbits×(`baud_div`+1) cycles after a raised `tx_en`. The bench samples on the falling clock edge, measures every low and high run in whole cycles, and compares them with those counts. It decodes data by stepping `baud_div`+1 cycles from the first low sample, so each bit is read in its own first cycle. The flags change one edge after a write and are read on the next falling edge.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [8:0]       wr_data,
  input  logic             wr_stb,
  input  logic             long_word,
  input  logic             tx_en,
  input  logic             brk_req,
  output logic             txd,
  output logic             data_empty,
  output logic             tx_done
);
  localparam int SH_W  = 12;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {K_DATA, K_BRK, K_IDLE} kind_t;

  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] bit_cnt;
  logic [DIV_W-1:0] pre_cnt;
  logic             busy, te_q, brk_q;
  logic             idle_pend, brk_pend, data_full;
  logic [8:0]       buf_q;
  kind_t            kind;

  logic             bit_end, last_bit, slot_free, brk_more, start;
  kind_t            ld_kind;
  logic [SH_W-1:0]  ld_sh;
  logic [CNT_W-1:0] nb, ld_cnt;

  assign bit_end   = busy && tick && (pre_cnt == baud_div);
  assign last_bit  = bit_end && (bit_cnt == CNT_W'(1));
  assign slot_free = !busy || last_bit;
  assign brk_more  = last_bit && (kind == K_BRK) && brk_req;
  assign start     = slot_free && tx_en && te_q &&
                     (idle_pend || brk_pend || brk_more || data_full);
  assign nb        = long_word ? CNT_W'(11) : CNT_W'(10);

  always_comb begin
    if (idle_pend) begin
      ld_kind = K_IDLE;
      ld_sh   = '1;
      ld_cnt  = nb;
    end else if (brk_pend || brk_more) begin
      ld_kind = K_BRK;
      ld_sh   = SH_W'(1) << nb;
      ld_cnt  = nb + CNT_W'(1);
    end else begin
      ld_kind = K_DATA;
      ld_sh   = long_word ? {2'b11, 1'b1, buf_q, 1'b0}
                          : {3'b111, 1'b1, buf_q[7:0], 1'b0};
      ld_cnt  = nb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '1;
      bit_cnt <= '0;
      pre_cnt <= '0;
      kind    <= K_IDLE;
    end else if (start) begin
      busy    <= 1'b1;
      sh      <= ld_sh;
      bit_cnt <= ld_cnt;
      pre_cnt <= '0;
      kind    <= ld_kind;
    end else if (last_bit) begin
      busy    <= 1'b0;
    end else if (bit_end) begin
      sh      <= {1'b1, sh[SH_W-1:1]};
      bit_cnt <= bit_cnt - CNT_W'(1);
      pre_cnt <= '0;
    end else if (busy && tick) begin
      pre_cnt <= pre_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q      <= 1'b0;
      brk_q     <= 1'b0;
      idle_pend <= 1'b0;
      brk_pend  <= 1'b0;
      data_full <= 1'b0;
      buf_q     <= '0;
    end else begin
      te_q  <= tx_en;
      brk_q <= brk_req;
      if (tx_en && !te_q)
        idle_pend <= 1'b1;
      else if (start && ld_kind == K_IDLE)
        idle_pend <= 1'b0;
      if (brk_req && !brk_q)
        brk_pend <= 1'b1;
      else if (start && ld_kind == K_BRK)
        brk_pend <= 1'b0;
      if (wr_stb) begin
        data_full <= 1'b1;
        buf_q     <= wr_data;
      end else if (start && ld_kind == K_DATA) begin
        data_full <= 1'b0;
      end
    end
  end

  assign txd        = busy ? sh[0] : 1'b1;
  assign data_empty = !data_full;
  assign tx_done    = !busy && !data_full && !idle_pend && !brk_pend;

  // R4
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && kind == K_BRK && bit_cnt > CNT_W'(1) |-> !txd);
  // R6
  frame_tail_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));
  // R9
  te_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && !busy |=> txd);
  // R4
  brk_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |=> brk_pend);
  // R10
  wr_done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !tx_done && !data_empty);
  // R11
  idle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && $past(idle_pend) |-> kind == K_IDLE);
endmodule

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;
  localparam int DIV_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b1;
  logic [DIV_W-1:0] baud_div = DIV_W'(3);
  logic [8:0]       wr_data = '0;
  logic             wr_stb = 1'b0;
  logic             long_word = 1'b0;
  logic             tx_en = 1'b0;
  logic             brk_req = 1'b0;
  logic             txd, data_empty, tx_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0, run_lo = 0, run_hi = 0, last_lo = 0, last_hi = 0, n_lo = 0, fall_cyc = 0;

  uart_tx_brk #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .baud_div(baud_div),
    .wr_data(wr_data), .wr_stb(wr_stb), .long_word(long_word),
    .tx_en(tx_en), .brk_req(brk_req), .txd(txd),
    .data_empty(data_empty), .tx_done(tx_done)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (txd === 1'b0) begin
        run_lo++;
        if (run_hi != 0) begin last_hi = run_hi; fall_cyc = cyc; end
        run_hi = 0;
      end else begin
        if (run_lo != 0) begin last_lo = run_lo; n_lo++; end
        run_lo = 0;
        run_hi++;
      end
    end
  end

  function automatic int nbits(input bit m);
    return m ? 11 : 10;
  endfunction

  function automatic logic [8:0] exp_word(input logic [8:0] w, input bit m);
    return m ? w : {1'b0, w[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_done;
    int t = 0;
    @(negedge clk);
    while (!tx_done && t < 5000) begin @(negedge clk); t++; end
    #2;
    chk(t < 5000, "R10 tx_done timeout", t, 5000);
  endtask

  task automatic write_word(input logic [8:0] v);
    @(negedge clk);
    wr_data = v; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic decode(input int bt, input bit m, output logic [8:0] d, output logic stop_v);
    int t = 0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    d = '0;
    for (int k = 0; k < (m ? 9 : 8); k++) begin
      repeat (bt) @(negedge clk);
      d[k] = txd;
    end
    repeat (bt) @(negedge clk);
    stop_v = txd;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    finish_run();
  end

  initial begin
    logic [8:0] d, w, w2;
    logic       sv;
    int         bt, n, n0, k0, hi_ok;
    bit         m;
    void'($urandom(32'd1234));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(data_empty === 1'b1, "R1 data_empty", data_empty, 1);
    chk(tx_done === 1'b1, "R1 tx_done", tx_done, 1);

    // R7: idle frame after enable
    bt = 4; m = 0;
    n0 = n_lo;
    @(negedge clk); tx_en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tx_done && n < 1000);
    #2;
    chk(n == 2 + nbits(m) * bt, "R7 idle length", n, 2 + nbits(m) * bt);
    chk(n_lo == n0 && run_lo == 0, "R7 line high in idle", n_lo - n0, 0);

    // R2 R3: random data frames
    for (int i = 0; i < 20; i++) begin
      m = 1'($urandom_range(0, 1));
      bt = $urandom_range(2, 7);
      long_word = m; baud_div = DIV_W'(bt - 1);
      w = 9'($urandom_range(0, 511));
      write_word(w);
      decode(bt, m, d, sv);
      chk(d == exp_word(w, m), m ? "R3 data bits" : "R2 data bits", d, exp_word(w, m));
      chk(sv === 1'b1, "R2 stop bit", sv, 1);
      wait_done();
    end

    // R4: single break pulses at random offsets
    for (int i = 0; i < 6; i++) begin
      m = 1'(i % 2);
      bt = $urandom_range(3, 9);
      long_word = m; baud_div = DIV_W'(bt - 1);
      n0 = n_lo;
      repeat ($urandom_range(0, 9)) @(negedge clk);
      @(negedge clk); brk_req = 1'b1;
      repeat ($urandom_range(1, 3)) @(negedge clk);
      brk_req = 1'b0;
      wait_done();
      chk(n_lo - n0 == 1, "R4 break count", n_lo - n0, 1);
      chk(last_lo == nbits(m) * bt, "R4 break length", last_lo, nbits(m) * bt);
    end

    // R5: held break request
    m = 1; bt = 5; long_word = m; baud_div = DIV_W'(bt - 1);
    n0 = n_lo;
    @(negedge clk); brk_req = 1'b1;
    n = 0;
    while (n_lo < n0 + 2 && n < 3000) begin @(negedge clk); n++; end
    #2;
    chk(last_lo == nbits(m) * bt, "R5 repeated break length", last_lo, nbits(m) * bt);
    chk(last_hi == bt, "R5 gap between breaks", last_hi, bt);
    @(negedge clk); brk_req = 1'b0;
    wait_done();
    chk(n_lo - n0 >= 2, "R5 break repeats", n_lo - n0, 2);
    chk(last_lo == nbits(m) * bt, "R5 final break length", last_lo, nbits(m) * bt);

    // R6 R11: break and data requested together
    m = 0; bt = 4; long_word = m; baud_div = DIV_W'(bt - 1);
    w = 9'h0A5;
    n0 = n_lo;
    @(negedge clk); wr_data = w; wr_stb = 1'b1; brk_req = 1'b1;
    @(negedge clk); wr_stb = 1'b0; brk_req = 1'b0;
    #2;
    chk(data_empty === 1'b0, "R10 data_empty after write", data_empty, 0);
    chk(tx_done === 1'b0, "R10 tx_done after write", tx_done, 0);
    n = 0;
    while (n_lo == n0 && n < 3000) begin @(negedge clk); n++; end
    #2;
    chk(last_lo == nbits(m) * bt, "R11 break before data", last_lo, nbits(m) * bt);
    decode(bt, m, d, sv);
    chk(d == exp_word(w, m), "R11 data after break", d, exp_word(w, m));
    chk(last_hi >= bt, "R6 high after break", last_hi, bt);
    wait_done();

    // R8: idle then break
    m = 1; bt = 3; long_word = m; baud_div = DIV_W'(bt - 1);
    n0 = n_lo;
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    #2; k0 = cyc;
    @(negedge clk); brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0;
    wait_done();
    chk(n_lo - n0 == 1, "R8 one break", n_lo - n0, 1);
    chk(last_lo == nbits(m) * bt, "R8 break length", last_lo, nbits(m) * bt);
    chk(fall_cyc - k0 == 2 + nbits(m) * bt, "R8 idle before break", fall_cyc - k0, 2 + nbits(m) * bt);

    // R9: enable dropped mid-frame
    m = 0; bt = 4; long_word = m; baud_div = DIV_W'(bt - 1);
    w = 9'h03C; w2 = 9'h0C3;
    write_word(w);
    write_word(w2);
    tx_en = 1'b0;
    decode(bt, m, d, sv);
    chk(d == exp_word(w, m), "R9 frame finishes", d, exp_word(w, m));
    hi_ok = 0;
    for (int i = 0; i < 3 * nbits(m) * bt; i++) begin
      @(negedge clk);
      if (txd === 1'b1 && data_empty === 1'b0 && tx_done === 1'b0) hi_ok++;
    end
    chk(hi_ok == 3 * nbits(m) * bt, "R9 line held high, word kept", hi_ok, 3 * nbits(m) * bt);
    tx_en = 1'b1;
    n0 = cyc;
    decode(bt, m, d, sv);
    chk(d == exp_word(w2, m), "R9 pending word after enable", d, exp_word(w2, m));
    chk(fall_cyc - n0 >= nbits(m) * bt, "R9 idle before word", fall_cyc - n0, nbits(m) * bt);
    wait_done();

    finish_run();
  end
endmodule